// File: doc/BRIEF.md
# DDR2 Bank Command Legality Tracker

This block sits beside a DDR2 memory controller's command scheduler and rules on every decoded command before it reaches the memory. It keeps a model of each bank (row open or closed, row-precharge wait still running or not), a device-wide wait for the mode-register delay and the refresh recovery time, a self-refresh flag, and a stored copy of the last mode register value written. Each presented command gets a one-cycle verdict: a legal pulse, or an illegal pulse with a reason code. An illegal command changes no state.

The controller presents one command per cycle on a plain strobe with an opcode, bank number, all-banks flag, auto-precharge flag, clock-enable level and mode data. It also reports whether an uninterruptible data burst is running. There is no back-pressure. The block never stalls the controller. It only reports, one cycle after the command, whether the command was allowed. All wait times are parameters counted in clock cycles, and each must be at least 1.

Top module: `ddr2_cmd_guard`

## Requirements
- R1: After reset every bank is closed, no verdict pulse is raised, the code is 0, self refresh is off, mode_loaded is 0 and mode_value is 0.
- R2: ACTIVATE (opcode 1) to a closed bank whose row-precharge wait has run out is legal and opens that bank. ACTIVATE to a bank that is already open is illegal with code 2 (busy).
- R3: READ (opcode 2) or WRITE (opcode 3) to a closed bank is illegal with code 1. The same command to an open bank while burst_busy is high is illegal with code 2. Otherwise it is legal, including while another bank is still precharging.
- R4: A legal READ or WRITE with cmd_autopre high closes its bank and starts that bank's row-precharge wait.
- R5: PRECHARGE (opcode 4) is always legal, outside self refresh and outside the device-wide wait. It closes the addressed bank, or every bank when cmd_all is high, and restarts the row-precharge wait of each target even if the target was already closed or precharging. An ACTIVATE to that bank fewer than T_RP cycles later is illegal with code 4.
- R6: REFRESH (opcode 5 with cmd_cke high) is illegal with code 3 if any bank is open, and with code 4 if any row-precharge wait is running. It ignores cmd_bank and cmd_all. A legal REFRESH starts a T_RFC wait, during which every non-idle command is illegal with code 4.
- R7: Opcode 5 with cmd_cke low enters self refresh under the same conditions as R6. In self refresh every command except exit (opcode 6) is illegal with code 5, and exit while not in self refresh is also code 5. A legal exit leaves self refresh and starts a T_RFC wait.
- R8: LOAD MODE (opcode 7) is illegal with code 3 if any bank is open, code 2 if burst_busy is high, and code 4 if a row-precharge wait runs, checked in that order. A legal one stores mode_data, sets mode_loaded and starts a T_MRD wait.
- R9: Bit DLL_RST_BIT of mode_value reads 1 only in the cycle right after the load that wrote it, and then clears. Every other bit holds until the next legal LOAD MODE.
- R10: Verdicts appear one cycle after the command. Opcode 0, or cmd_valid low, gives no pulse. An illegal command leaves bank, self-refresh and mode state unchanged. The self-refresh check comes first, then the device-wide wait, then the checks for each command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Opcode: 0 idle, 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 self-refresh exit, 7 load mode |
| cmd_bank | input | BA_W | Target bank |
| cmd_all | input | 1 | Precharge applies to all banks |
| cmd_autopre | input | 1 | Read/write closes its bank afterwards |
| cmd_cke | input | 1 | Clock-enable level; low with opcode 5 selects self-refresh entry |
| burst_busy | input | 1 | An uninterruptible data burst is in progress |
| mode_data | input | MR_W | Value written by load mode |
| resp_legal | output | 1 | One-cycle pulse: previous command allowed |
| resp_illegal | output | 1 | One-cycle pulse: previous command refused |
| resp_code | output | 3 | Reason: 0 none, 1 bank closed, 2 busy, 3 not all idle, 4 wait running, 5 self-refresh state |
| bank_open | output | NUM_BANKS | One bit per bank, 1 = row open |
| self_refresh | output | 1 | Device is in self refresh |
| mode_loaded | output | 1 | A load mode has been accepted since reset |
| mode_value | output | MR_W | Stored mode register copy |

## Verification
The hardest state to reach is a collision of several waits. One example is an ACTIVATE that arrives exactly T_RP cycles after a precharge that was itself a restart on an already-precharging bank. Another is a REFRESH while one bank's wait is still running and every bank is closed. Directed sequences count cycles to land on each boundary and one cycle before it. A long randomized stream then mixes auto-precharge, self refresh and load mode, with a behavioural model that records, for each bank, the cycle of its last precharge.

// File: rtl/ddr2_guard_pkg.sv
package ddr2_guard_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_REF = 3'd5,
    OP_SRX = 3'd6,
    OP_LMR = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    VC_NONE     = 3'd0,
    VC_NOT_OPEN = 3'd1,
    VC_BUSY     = 3'd2,
    VC_NOT_IDLE = 3'd3,
    VC_WAIT     = 3'd4,
    VC_SELFREF  = 3'd5
  } viol_e;
endpackage

// File: rtl/ddr2_bank_slot.sv
module ddr2_bank_slot #(
  parameter int T_RP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_req,
  input  logic close_req,
  output logic is_open,
  output logic rp_busy
);
  localparam int CW = (T_RP < 2) ? 1 : $clog2(T_RP + 1);
  localparam logic [CW-1:0] RELOAD = CW'(T_RP - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      cnt     <= '0;
    end else if (close_req) begin
      is_open <= 1'b0;
      cnt     <= RELOAD;
    end else begin
      if (open_req) is_open <= 1'b1;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign rp_busy = (cnt != '0);
endmodule

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
  parameter int T_MRD = 2,
  parameter int T_RFC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_mrd,
  input  logic load_rfc,
  output logic busy
);
  localparam int LONGEST = (T_MRD > T_RFC) ? T_MRD : T_RFC;
  localparam int CW = (LONGEST < 2) ? 1 : $clog2(LONGEST + 1);
  localparam logic [CW-1:0] MRD_LD = CW'(T_MRD - 1);
  localparam logic [CW-1:0] RFC_LD = CW'(T_RFC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load_rfc)      cnt <= RFC_LD;
    else if (load_mrd)      cnt <= MRD_LD;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/ddr2_cmd_judge.sv
module ddr2_cmd_judge
  import ddr2_guard_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int BA_W = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
  input  logic                 cmd_valid,
  input  op_e                  op,
  input  logic [BA_W-1:0]      bank,
  input  logic                 all_banks,
  input  logic                 autopre,
  input  logic                 cke,
  input  logic                 burst_busy,
  input  logic [NUM_BANKS-1:0] bank_open,
  input  logic [NUM_BANKS-1:0] rp_busy,
  input  logic                 wait_busy,
  input  logic                 in_sr,
  output logic                 ok,
  output logic                 bad,
  output viol_e                code,
  output logic [NUM_BANKS-1:0] open_mask,
  output logic [NUM_BANKS-1:0] close_mask,
  output logic                 do_ref,
  output logic                 do_sre,
  output logic                 do_srx,
  output logic                 do_lmr
);
  logic [NUM_BANKS-1:0] sel;
  logic any_open, any_rp, tgt_open, tgt_rp;

  assign sel      = NUM_BANKS'(1) << bank;
  assign any_open = |bank_open;
  assign any_rp   = |rp_busy;
  assign tgt_open = |(bank_open & sel);
  assign tgt_rp   = |(rp_busy & sel);

  always_comb begin
    ok         = 1'b0;
    bad        = 1'b0;
    code       = VC_NONE;
    open_mask  = '0;
    close_mask = '0;
    do_ref     = 1'b0;
    do_sre     = 1'b0;
    do_srx     = 1'b0;
    do_lmr     = 1'b0;
    if (cmd_valid && op != OP_NOP) begin
      if (in_sr) begin
        if (op == OP_SRX) do_srx = 1'b1;
        else              code   = VC_SELFREF;
      end else if (op == OP_SRX) begin
        code = VC_SELFREF;
      end else if (wait_busy) begin
        code = VC_WAIT;
      end else begin
        case (op)
          OP_ACT: begin
            if (tgt_open)    code = VC_BUSY;
            else if (tgt_rp) code = VC_WAIT;
            else             open_mask = sel;
          end
          OP_RD, OP_WR: begin
            if (!tgt_open)       code = VC_NOT_OPEN;
            else if (burst_busy) code = VC_BUSY;
            else if (autopre)    close_mask = sel;
          end
          OP_PRE: close_mask = all_banks ? {NUM_BANKS{1'b1}} : sel;
          OP_REF: begin
            if (any_open)    code = VC_NOT_IDLE;
            else if (any_rp) code = VC_WAIT;
            else if (cke)    do_ref = 1'b1;
            else             do_sre = 1'b1;
          end
          OP_LMR: begin
            if (any_open)        code = VC_NOT_IDLE;
            else if (burst_busy) code = VC_BUSY;
            else if (any_rp)     code = VC_WAIT;
            else                 do_lmr = 1'b1;
          end
          default: ;
        endcase
      end
      ok  = (code == VC_NONE);
      bad = (code != VC_NONE);
      if (bad) begin
        open_mask  = '0;
        close_mask = '0;
      end
    end
  end
endmodule

// File: rtl/ddr2_cmd_guard.sv
module ddr2_cmd_guard
  import ddr2_guard_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int T_RP        = 4,
  parameter int T_MRD       = 2,
  parameter int T_RFC       = 12,
  parameter int MR_W        = 14,
  parameter int DLL_RST_BIT = 8,
  localparam int BA_W = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [2:0]           cmd_op,
  input  logic [BA_W-1:0]      cmd_bank,
  input  logic                 cmd_all,
  input  logic                 cmd_autopre,
  input  logic                 cmd_cke,
  input  logic                 burst_busy,
  input  logic [MR_W-1:0]      mode_data,
  output logic                 resp_legal,
  output logic                 resp_illegal,
  output logic [2:0]           resp_code,
  output logic [NUM_BANKS-1:0] bank_open,
  output logic                 self_refresh,
  output logic                 mode_loaded,
  output logic [MR_W-1:0]      mode_value
);
  op_e                  op;
  viol_e                code;
  logic                 ok, bad, do_ref, do_sre, do_srx, do_lmr, wait_busy;
  logic [NUM_BANKS-1:0] open_mask, close_mask, rp_busy;

  assign op = op_e'(cmd_op);

  ddr2_cmd_judge #(.NUM_BANKS(NUM_BANKS)) u_judge (
    .cmd_valid  (cmd_valid),
    .op         (op),
    .bank       (cmd_bank),
    .all_banks  (cmd_all),
    .autopre    (cmd_autopre),
    .cke        (cmd_cke),
    .burst_busy (burst_busy),
    .bank_open  (bank_open),
    .rp_busy    (rp_busy),
    .wait_busy  (wait_busy),
    .in_sr      (self_refresh),
    .ok         (ok),
    .bad        (bad),
    .code       (code),
    .open_mask  (open_mask),
    .close_mask (close_mask),
    .do_ref     (do_ref),
    .do_sre     (do_sre),
    .do_srx     (do_srx),
    .do_lmr     (do_lmr)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    ddr2_bank_slot #(.T_RP(T_RP)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .open_req  (open_mask[b]),
      .close_req (close_mask[b]),
      .is_open   (bank_open[b]),
      .rp_busy   (rp_busy[b])
    );
  end

  ddr2_wait_timer #(.T_MRD(T_MRD), .T_RFC(T_RFC)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_mrd (do_lmr),
    .load_rfc (do_ref | do_srx),
    .busy     (wait_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_legal   <= 1'b0;
      resp_illegal <= 1'b0;
      resp_code    <= 3'd0;
      self_refresh <= 1'b0;
      mode_loaded  <= 1'b0;
      mode_value   <= '0;
    end else begin
      resp_legal   <= ok;
      resp_illegal <= bad;
      resp_code    <= code;
      if (do_sre)      self_refresh <= 1'b1;
      else if (do_srx) self_refresh <= 1'b0;
      if (do_lmr) begin
        mode_value  <= mode_data;
        mode_loaded <= 1'b1;
      end else begin
        mode_value[DLL_RST_BIT] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ddr2_cmd_guard_chk.sv
module ddr2_cmd_guard_chk #(
  parameter int NUM_BANKS   = 8,
  parameter int MR_W        = 14,
  parameter int DLL_RST_BIT = 8,
  localparam int BA_W = (NUM_BANKS < 2) ? 1 : $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic [2:0]           cmd_op,
  input logic [BA_W-1:0]      cmd_bank,
  input logic                 cmd_cke,
  input logic                 burst_busy,
  input logic                 resp_legal,
  input logic                 resp_illegal,
  input logic [2:0]           resp_code,
  input logic [NUM_BANKS-1:0] bank_open,
  input logic                 self_refresh,
  input logic [MR_W-1:0]      mode_value
);
  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_legal && resp_illegal));

  assert_code_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_illegal == (resp_code != 3'd0));

  assert_illegal_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_illegal |-> (bank_open == $past(bank_open)) && (self_refresh == $past(self_refresh)));

  assert_rw_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3) && !bank_open[cmd_bank]) |=> resp_illegal);

  assert_open_by_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_open & ~$past(bank_open)) != '0) |-> (resp_legal && $past(cmd_op) == 3'd1));

  assert_ref_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5 && (|bank_open)) |=> resp_illegal);

  assert_sr_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_refresh) |-> $past(cmd_valid && cmd_op == 3'd5 && !cmd_cke));

  assert_lmr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd7 && ((|bank_open) || burst_busy)) |=> resp_illegal);

  assert_dll_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_value[DLL_RST_BIT] && !(cmd_valid && cmd_op == 3'd7)) |=> !mode_value[DLL_RST_BIT]);
endmodule

bind ddr2_cmd_guard ddr2_cmd_guard_chk #(
  .NUM_BANKS(NUM_BANKS), .MR_W(MR_W), .DLL_RST_BIT(DLL_RST_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_bank(cmd_bank), .cmd_cke(cmd_cke), .burst_busy(burst_busy),
  .resp_legal(resp_legal), .resp_illegal(resp_illegal), .resp_code(resp_code),
  .bank_open(bank_open), .self_refresh(self_refresh), .mode_value(mode_value)
);

// File: tb/ddr2_cmd_guard_tb.sv
module ddr2_cmd_guard_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int BW = 3;
  localparam int TRP = 4;
  localparam int TMRD = 2;
  localparam int TRFC = 12;
  localparam int MRW = 14;
  localparam int DLLB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [BW-1:0] cmd_bank = '0;
  logic cmd_all = 1'b0, cmd_autopre = 1'b0, cmd_cke = 1'b1, burst_busy = 1'b0;
  logic [MRW-1:0] mode_data = '0;
  logic resp_legal, resp_illegal, self_refresh, mode_loaded;
  logic [2:0] resp_code;
  logic [NB-1:0] bank_open;
  logic [MRW-1:0] mode_value;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_open[NB];
  int m_last_pre[NB];
  int m_wait_until = 0;
  bit m_sr = 0;
  logic [MRW-1:0] m_mr = '0;
  bit m_loaded = 0;
  int m_lmr_at = -10;
  int n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr2_cmd_guard #(.NUM_BANKS(NB), .T_RP(TRP), .T_MRD(TMRD), .T_RFC(TRFC),
                   .MR_W(MRW), .DLL_RST_BIT(DLLB)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_all(cmd_all), .cmd_autopre(cmd_autopre),
    .cmd_cke(cmd_cke), .burst_busy(burst_busy), .mode_data(mode_data),
    .resp_legal(resp_legal), .resp_illegal(resp_illegal), .resp_code(resp_code),
    .bank_open(bank_open), .self_refresh(self_refresh), .mode_loaded(mode_loaded),
    .mode_value(mode_value));

  task automatic chk(input bit good, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, n);
    end
  endtask

  function automatic bit any_open();
    for (int b = 0; b < NB; b++) if (m_open[b]) return 1;
    return 0;
  endfunction

  function automatic bit any_rp();
    for (int b = 0; b < NB; b++) if (n - m_last_pre[b] < TRP) return 1;
    return 0;
  endfunction

  task automatic step(input int op, input int bank, input bit all, input bit ap,
                      input bit cke, input bit burst, input logic [MRW-1:0] data,
                      input bit valid, input string tag);
    bit e_ok, e_bad;
    int e_code;
    logic [NB-1:0] e_open;
    logic [MRW-1:0] e_mr;
    cmd_valid = valid; cmd_op = 3'(op); cmd_bank = BW'(bank); cmd_all = all;
    cmd_autopre = ap; cmd_cke = cke; burst_busy = burst; mode_data = data;
    @(posedge clk);
    e_code = 0; e_ok = 0; e_bad = 0;
    if (valid && op != 0) begin
      if (m_sr) begin
        if (op == 6) begin m_sr = 0; m_wait_until = n + TRFC; end
        else e_code = 5;
      end else if (op == 6) e_code = 5;
      else if (n < m_wait_until) e_code = 4;
      else begin
        case (op)
          1: if (m_open[bank]) e_code = 2;
             else if (n - m_last_pre[bank] < TRP) e_code = 4;
             else m_open[bank] = 1;
          2, 3: if (!m_open[bank]) e_code = 1;
                else if (burst) e_code = 2;
                else if (ap) begin m_open[bank] = 0; m_last_pre[bank] = n; end
          4: for (int b = 0; b < NB; b++)
               if (all || b == bank) begin m_open[b] = 0; m_last_pre[b] = n; end
          5: if (any_open()) e_code = 3;
             else if (any_rp()) e_code = 4;
             else if (cke) m_wait_until = n + TRFC;
             else m_sr = 1;
          7: if (any_open()) e_code = 3;
             else if (burst) e_code = 2;
             else if (any_rp()) e_code = 4;
             else begin m_mr = data; m_loaded = 1; m_lmr_at = n; m_wait_until = n + TMRD; end
          default: ;
        endcase
      end
      e_ok = (e_code == 0);
      e_bad = (e_code != 0);
    end
    for (int b = 0; b < NB; b++) e_open[b] = m_open[b];
    e_mr = m_mr;
    if (m_lmr_at != n) e_mr[DLLB] = 1'b0;
    @(negedge clk);
    chk(resp_legal == e_ok, tag, "legal", resp_legal, e_ok);
    chk(resp_illegal == e_bad, tag, "illegal", resp_illegal, e_bad);
    chk(resp_code == 3'(e_code), tag, "code", resp_code, e_code);
    chk(bank_open == e_open, tag, "bank_open", bank_open, e_open);
    chk(self_refresh == m_sr, "R7", "self_refresh", self_refresh, m_sr);
    chk(mode_loaded == m_loaded, "R8", "mode_loaded", mode_loaded, m_loaded);
    chk(mode_value == e_mr, "R9", "mode_value", mode_value, e_mr);
    n++;
  endtask

  task automatic cmd(input int op, input int bank, input string tag);
    step(op, bank, 0, 0, 1, 0, '0, 1, tag);
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, 0, 1, 0, '0, 1, "R10");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_last_pre[b] = -1000; end
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(bank_open == '0, "R1", "bank_open", bank_open, 0);
    chk(!resp_legal && !resp_illegal, "R1", "pulses", {resp_legal, resp_illegal}, 0);
    chk(resp_code == 0, "R1", "code", resp_code, 0);
    chk(!self_refresh && !mode_loaded, "R1", "sr/loaded", {self_refresh, mode_loaded}, 0);
    chk(mode_value == '0, "R1", "mode_value", mode_value, 0);
    rst_n = 1'b1;

    cmd(2, 0, "R3");                          // read closed bank: code 1
    cmd(1, 0, "R2");                          // open bank 0
    cmd(1, 0, "R2");                          // already open: code 2
    cmd(2, 0, "R3");                          // legal read
    step(3, 0, 0, 0, 1, 1, '0, 1, "R3");      // write during burst: code 2
    cmd(1, 1, "R2");
    cmd(5, 0, "R6");                          // refresh with open banks: code 3
    cmd(7, 0, "R8");                          // load mode with open banks: code 3
    cmd(4, 0, "R5");                          // close bank 0
    cmd(1, 0, "R5");                          // too early: code 4
    idle(TRP - 3);
    cmd(4, 0, "R5");                          // re-precharge precharging bank: restart
    idle(TRP - 2);
    cmd(1, 0, "R5");                          // one cycle early after restart: code 4
    cmd(1, 0, "R5");                          // exactly T_RP after restart: legal
    step(4, 0, 1, 0, 1, 0, '0, 1, "R5");      // precharge all
    cmd(4, 2, "R5");                          // precharge of idle bank: legal
    cmd(5, 0, "R6");                          // wait running: code 4
    idle(TRP - 2);
    step(5, 6, 1, 0, 1, 0, '0, 1, "R6");      // refresh, bank/all ignored
    cmd(1, 3, "R6");                          // inside refresh wait: code 4
    idle(TRFC - 3);
    cmd(1, 3, "R6");                          // last cycle of wait: code 4
    step(7, 0, 0, 0, 1, 0, '0, 1, "R6");      // wait over; bank 3 not opened so all idle
    step(7, 0, 0, 0, 1, 1, 14'h1555, 1, "R8"); // burst busy: code 2 (or wait)
    idle(TMRD);
    step(7, 0, 0, 0, 1, 1, 14'h1555, 1, "R8"); // burst busy: code 2
    step(7, 0, 0, 0, 1, 0, 14'h3fff, 1, "R8"); // legal, sets DLL bit
    cmd(1, 3, "R9");                          // mode-delay wait: code 4; DLL bit cleared
    idle(TMRD);
    cmd(1, 3, "R4");
    step(2, 3, 0, 1, 1, 0, '0, 1, "R4");      // read with auto precharge
    cmd(1, 3, "R4");                          // precharging: code 4
    cmd(1, 4, "R3");
    cmd(2, 4, "R3");                          // read while bank 3 precharges: legal
    cmd(4, 4, "R5");
    idle(TRP);
    step(5, 0, 0, 0, 0, 0, '0, 1, "R7");      // self-refresh entry
    cmd(1, 0, "R7");                          // code 5
    cmd(4, 0, "R7");                          // code 5
    cmd(6, 0, "R7");                          // exit
    cmd(1, 0, "R7");                          // refresh wait after exit: code 4
    cmd(6, 0, "R7");                          // exit when not in self refresh: code 5
    step(1, 0, 0, 0, 1, 0, '0, 0, "R10");     // valid low: nothing
    idle(TRFC);

    for (int i = 0; i < 3000; i++) begin
      int op;
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 22) op = 1;
      else if (r < 40) op = 2;
      else if (r < 52) op = 3;
      else if (r < 66) op = 4;
      else if (r < 76) op = 5;
      else if (r < 82) op = 6;
      else if (r < 88) op = 7;
      else op = 0;
      step(op, int'($urandom_range(0, NB - 1)), ($urandom_range(0, 3) == 0),
           $urandom_range(0, 1) == 1, ($urandom_range(0, 5) != 0),
           ($urandom_range(0, 3) == 0), MRW'($urandom), ($urandom_range(0, 9) != 0),
           (op == 1) ? "R2" : (op == 2 || op == 3) ? "R3" : (op == 4) ? "R5" :
           (op == 5) ? "R6" : (op == 6) ? "R7" : (op == 7) ? "R8" : "R10");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule